// File: doc/BRIEF.md
# Event-Configuration Register Access Resolver

This block sits between the system-register decode path and a small file of per-counter event-configuration words. Each request names an entry by a five-bit index, taken from two encoding fields, and carries a direction. The block weighs the current privilege level, the user-access enable, the trap controls owned by levels 2 and 3, and the fine-grained read and write trap bits. It then returns exactly one verdict: carry out the access, raise undefined, or trap to level 1, 2 or 3 with a fixed syndrome class.

The block also checks the index against two limits. The first is the number of counters actually built, which is a parameter. The second is a programmable limit set by level 2. When the access proceeds, a write updates the selected entry and a read returns it on the cycle the verdict appears. The block does not count events and does not run the exception entry sequence.

Top module: `evt_cfg_access`

## Requirements
- R1: The entry index is `{crm_lo_i[1:0], op2_i[2:0]}`, with crm_lo_i as the upper two bits, giving indices 0 to 30 for the default of 31 counters. A write that proceeds stores data in that entry, and a later read of the same index returns it.
- R2: Exactly one of acc_o, undef_o and trap_o is high in the cycle after a request strobe. All three are low in the cycle after a cycle with no request.
- R3: When trap_o is high, syn_o equals 0x18 and trap_el_o holds the target level (1, 2 or 3). When trap_o is low, trap_el_o and syn_o are 0.
- R4: At level 0 with user access disabled, the access traps to level 2 if level 2 is enabled and tge_i is 1. Otherwise it traps to level 1.
- R5: At levels 0 and 1, the fine-grained bit that matches the direction (fgt_rd_i for reads, fgt_wr_i for writes) traps to level 2. This applies only when level 2 is enabled and, with level 3 present, only when fgt_en_i is 1. At level 0 the check is skipped when e2h_i and tge_i are both 1.
- R6: At levels 0 and 1, after the fine-grained check, tpm2_i traps to level 2 when level 2 is enabled. After that, tpm3_i traps to level 3.
- R7: At level 2 only tpm3_i is checked, and it traps to level 3. At level 3 every access proceeds.
- R8: With fine-grained traps built and level 2 enabled, an access from level 0 or 1 to an index at or above NUM_CNT is undefined, ahead of every trap. After the trap chain, such an access to an index at or above lim_i traps to level 2.
- R9: An access that proceeds to an index at or above the accessible count reads as zero and leaves the register file unchanged. The accessible count is lim_i at levels 0 and 1 with level 2 enabled, and NUM_CNT otherwise.
- R10: Stored bits 23:16 always read as zero. A write that traps or is undefined leaves its entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, one cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| el_i | input | 2 | Current privilege level, 0 to 3 |
| crm_lo_i | input | 2 | Upper two bits of the entry index |
| op2_i | input | 3 | Lower three bits of the entry index |
| wdata_i | input | 32 | Write data |
| usr_en_i | input | 1 | User-level access enable |
| el2_en_i | input | 1 | Level 2 enabled in the current state |
| tge_i | input | 1 | Level 2 routes level 0 exceptions to itself |
| e2h_i | input | 1 | Level 2 host mode |
| fgt_en_i | input | 1 | Level 3 enable for fine-grained traps |
| fgt_rd_i | input | 1 | Fine-grained trap on read |
| fgt_wr_i | input | 1 | Fine-grained trap on write |
| tpm2_i | input | 1 | Level 2 counter-register trap |
| tpm3_i | input | 1 | Level 3 counter-register trap |
| lim_i | input | CNT_W | Counter limit set by level 2 |
| acc_o | output | 1 | Access performed |
| undef_o | output | 1 | Access undefined |
| trap_o | output | 1 | Access trapped |
| trap_el_o | output | 2 | Trap target level |
| syn_o | output | 6 | Syndrome class of the trap |
| rdata_o | output | 32 | Read data |

## Verification
On every cycle, the assertions check the properties that need no knowledge of the trap inputs' order: the one-hot, one-cycle verdict, the syndrome and level coding, the fact that level 3 always proceeds, the fact that level 2 can reach only level 3, the targets a user-disabled access can reach, zero reads beyond the accessible count, and the reserved bits of the stored data. The priority chain itself can only be shown by the bench's scenarios. Each scenario sets several trap conditions at once and confirms which one wins. Examples are an undefined index overriding the user-access trap, the level 3 trap overriding the limit trap, and the fine-grained skip that needs both host bits. The scenarios also show that trapped and ignored writes leave the stored words unchanged.

// File: rtl/evt_acc_pkg.sv
package evt_acc_pkg;
  localparam int REG_W = 32;
  localparam int IDX_W = 5;
  localparam logic [5:0] SYN_CLASS = 6'h18;
  localparam logic [REG_W-1:0] KEEP_MASK = 32'hFF00_FFFF;

  typedef enum logic [1:0] {RES_NONE, RES_ACC, RES_UNDEF, RES_TRAP} res_e;

  typedef struct packed {
    res_e       res;
    logic [1:0] tel;
    logic       raz;
  } dec_t;
endpackage

// File: rtl/evt_acc_decide.sv
module evt_acc_decide
  import evt_acc_pkg::*;
#(
  parameter int NUM_CNT = 31,
  parameter int CNT_W   = 5,
  parameter int HAS_EL3 = 1,
  parameter int HAS_FGT = 1
) (
  input  logic [1:0]       el_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [CNT_W-1:0] lim_i,
  input  logic             usr_en_i,
  input  logic             el2_en_i,
  input  logic             tge_i,
  input  logic             e2h_i,
  input  logic             fgt_en_i,
  input  logic             fgt_rd_i,
  input  logic             fgt_wr_i,
  input  logic             tpm2_i,
  input  logic             tpm3_i,
  output dec_t             dec_o
);
  localparam bit P_EL3 = (HAS_EL3 != 0);
  localparam bit P_FGT = (HAS_FGT != 0);
  localparam logic [5:0] NUM_L = 6'(NUM_CNT);

  logic [5:0] idx_x, lim_x;
  logic low_el, lim_on, unimpl, over_lim, fg_hit, fg_skip;

  assign idx_x    = {1'b0, idx_i};
  assign lim_x    = 6'(lim_i);
  assign low_el   = ~el_i[1];
  assign lim_on   = el2_en_i & low_el;
  assign unimpl   = idx_x >= NUM_L;
  assign over_lim = idx_x >= lim_x;
  assign fg_hit   = P_FGT & el2_en_i & (~P_EL3 | fgt_en_i) & (wr_i ? fgt_wr_i : fgt_rd_i);
  assign fg_skip  = (el_i == 2'd0) & e2h_i & tge_i;

  always_comb begin
    dec_o = '{res: RES_ACC, tel: 2'd0, raz: 1'b0};
    if (P_FGT && lim_on && unimpl) begin
      dec_o.res = RES_UNDEF;
    end else if (el_i == 2'd0 && !usr_en_i) begin
      dec_o.res = RES_TRAP;
      dec_o.tel = (el2_en_i && tge_i) ? 2'd2 : 2'd1;
    end else if (low_el && fg_hit && !fg_skip) begin
      dec_o.res = RES_TRAP;
      dec_o.tel = 2'd2;
    end else if (low_el && el2_en_i && tpm2_i) begin
      dec_o.res = RES_TRAP;
      dec_o.tel = 2'd2;
    end else if (el_i != 2'd3 && P_EL3 && tpm3_i) begin
      dec_o.res = RES_TRAP;
      dec_o.tel = 2'd3;
    end else if (P_FGT && lim_on && over_lim) begin
      dec_o.res = RES_TRAP;
      dec_o.tel = 2'd2;
    end else if (unimpl || (lim_on && over_lim)) begin
      dec_o.raz = 1'b1;
    end
  end
endmodule

// File: rtl/evt_type_file.sv
module evt_type_file
  import evt_acc_pkg::*;
#(
  parameter int NUM_CNT = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o
);
  logic [REG_W-1:0] mem [NUM_CNT];

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem[g] <= '0;
      else if (we_i && idx_i == IDX_W'(g))          mem[g] <= wdata_i & KEEP_MASK;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (idx_i == IDX_W'(i)) rdata_o = mem[i];
  end

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~KEEP_MASK) == '0); // R10
endmodule

// File: rtl/evt_cfg_access.sv
module evt_cfg_access
  import evt_acc_pkg::*;
#(
  parameter int NUM_CNT = 31,
  parameter int HAS_EL3 = 1,
  parameter int HAS_FGT = 1,
  localparam int CNT_W  = $clog2(NUM_CNT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic [1:0]       el_i,
  input  logic [1:0]       crm_lo_i,
  input  logic [2:0]       op2_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             usr_en_i,
  input  logic             el2_en_i,
  input  logic             tge_i,
  input  logic             e2h_i,
  input  logic             fgt_en_i,
  input  logic             fgt_rd_i,
  input  logic             fgt_wr_i,
  input  logic             tpm2_i,
  input  logic             tpm3_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             acc_o,
  output logic             undef_o,
  output logic             trap_o,
  output logic [1:0]       trap_el_o,
  output logic [5:0]       syn_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam logic [5:0] NUM_L = 6'(NUM_CNT);

  logic [IDX_W-1:0] idx;
  dec_t             dec;
  logic             go, we;
  logic [REG_W-1:0] rf_rdata;

  assign idx = {crm_lo_i, op2_i};

  evt_acc_decide #(
    .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .HAS_EL3(HAS_EL3), .HAS_FGT(HAS_FGT)
  ) u_decide (
    .el_i(el_i), .wr_i(wr_i), .idx_i(idx), .lim_i(lim_i),
    .usr_en_i(usr_en_i), .el2_en_i(el2_en_i), .tge_i(tge_i), .e2h_i(e2h_i),
    .fgt_en_i(fgt_en_i), .fgt_rd_i(fgt_rd_i), .fgt_wr_i(fgt_wr_i),
    .tpm2_i(tpm2_i), .tpm3_i(tpm3_i), .dec_o(dec)
  );

  assign go = req_i && dec.res == RES_ACC && !dec.raz;
  assign we = go && wr_i;

  evt_type_file #(.NUM_CNT(NUM_CNT)) u_file (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we), .idx_i(idx),
    .wdata_i(wdata_i), .rdata_o(rf_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o     <= 1'b0;
      undef_o   <= 1'b0;
      trap_o    <= 1'b0;
      trap_el_o <= 2'd0;
      rdata_o   <= '0;
    end else begin
      acc_o     <= req_i && dec.res == RES_ACC;
      undef_o   <= req_i && dec.res == RES_UNDEF;
      trap_o    <= req_i && dec.res == RES_TRAP;
      trap_el_o <= (req_i && dec.res == RES_TRAP) ? dec.tel : 2'd0;
      rdata_o   <= (go && !wr_i) ? rf_rdata : '0;
    end
  end

  assign syn_o = trap_o ? SYN_CLASS : 6'd0;

  AST_ONE_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({acc_o, undef_o, trap_o})); // R2
  AST_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (acc_o || undef_o || trap_o)); // R2
  AST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !(acc_o || undef_o || trap_o)); // R2
  AST_TRAP_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (syn_o == 6'h18 && trap_el_o != 2'd0)); // R3
  AST_NO_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |-> trap_el_o == 2'd0); // R3
  AST_USR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && el_i == 2'd0 && !usr_en_i) |=> (undef_o || (trap_o && trap_el_o != 2'd3))); // R4
  AST_TOP_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && el_i == 2'd3) |=> acc_o); // R7
  AST_EL2_ONLY3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && el_i == 2'd2) |=> (!trap_o || trap_el_o == 2'd3)); // R7
  AST_RAZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o && {1'b0, $past(crm_lo_i), $past(op2_i)} >= NUM_L) |-> rdata_o == '0); // R9
endmodule

// File: tb/sim_evt_cfg_access.sv
module sim_evt_cfg_access;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req, wr, usr, el2, tge, e2h, fgten, fgtr, fgtw, tpm2, tpm3;
  logic [1:0] el, crm;
  logic [2:0] op2;
  logic [4:0] lim;
  logic [31:0] wd;
  logic acc, undf, trp;
  logic [1:0] tel;
  logic [5:0] syn;
  logic [31:0] rd;

  int checks = 0, errors = 0;
  bit done = 0;

  evt_cfg_access u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .el_i(el),
    .crm_lo_i(crm), .op2_i(op2), .wdata_i(wd), .usr_en_i(usr), .el2_en_i(el2),
    .tge_i(tge), .e2h_i(e2h), .fgt_en_i(fgten), .fgt_rd_i(fgtr), .fgt_wr_i(fgtw),
    .tpm2_i(tpm2), .tpm3_i(tpm3), .lim_i(lim), .acc_o(acc), .undef_o(undf),
    .trap_o(trp), .trap_el_o(tel), .syn_o(syn), .rdata_o(rd)
  );

  // el wr usr el2 tge e2h fgten fgtr fgtw tpm2 tpm3 idx lim verdict(4=acc,2=undef,1=trap) tel req
  localparam int NV = 21;
  localparam int VT [NV][16] = '{
    '{0,0,0,1,0,0,0,0,0,0,0, 3,31,1,1,4},  // R4 user off -> 1
    '{0,0,0,1,1,0,0,0,0,0,0, 3,31,1,2,4},  // R4 tge -> 2
    '{0,0,0,0,1,0,0,0,0,0,0, 3,31,1,1,4},  // R4 tge, no level 2 -> 1
    '{0,0,1,1,0,0,1,1,0,0,0, 3,31,1,2,5},  // R5 read fgt
    '{0,0,1,1,1,1,1,1,0,0,0, 3,31,4,0,5},  // R5 skipped e2h&tge
    '{0,0,1,1,0,1,1,1,0,0,0, 3,31,1,2,5},  // R5 e2h alone no skip
    '{0,1,1,1,0,0,1,1,0,0,0, 3,31,4,0,5},  // R5 write ignores read bit
    '{1,1,1,1,0,0,1,0,1,0,0, 3,31,1,2,5},  // R5 write fgt at 1
    '{1,0,1,1,0,0,0,1,0,0,0, 3,31,4,0,5},  // R5 fgt_en low
    '{1,0,1,1,0,0,0,0,0,1,0, 3,31,1,2,6},  // R6 tpm2
    '{1,0,1,0,0,0,0,0,0,1,1, 3,31,1,3,6},  // R6 tpm2 gated, tpm3
    '{0,0,1,1,0,0,0,0,0,1,1, 3,31,1,2,6},  // R6 tpm2 before tpm3
    '{2,0,1,1,0,0,1,1,0,1,0, 3,31,4,0,7},  // R7 level 2 ignores lower traps
    '{2,0,1,1,0,0,0,0,0,0,1, 3,31,1,3,7},  // R7 level 2 tpm3
    '{3,0,1,1,0,0,1,1,0,1,1, 3,31,4,0,7},  // R7 level 3 always
    '{1,0,1,1,0,0,0,0,0,0,0,31,31,2,0,8},  // R8 unimplemented
    '{0,0,0,1,0,0,0,0,0,0,0,31,31,2,0,8},  // R8 undef beats user trap
    '{1,0,1,1,0,0,0,0,0,0,0, 8, 8,1,2,8},  // R8 at limit
    '{1,0,1,1,0,0,0,0,0,0,1, 8, 8,1,3,8},  // R8 tpm3 beats limit
    '{2,0,1,1,0,0,0,0,0,0,0, 8, 8,4,0,8},  // R8 level 2 no limit
    '{1,0,1,1,0,0,0,0,0,0,0, 7, 8,4,0,8}   // R8 just below limit
  };

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic set_in(input int e, w, u, l2, tg, eh, fe, fr, fw, t2, t3, ix, lm, input logic [31:0] d);
    el = 2'(e); wr = 1'(w); usr = 1'(u); el2 = 1'(l2); tge = 1'(tg); e2h = 1'(eh);
    fgten = 1'(fe); fgtr = 1'(fr); fgtw = 1'(fw); tpm2 = 1'(t2); tpm3 = 1'(t3);
    crm = 2'(ix >> 3); op2 = 3'(ix); lim = 5'(lm); wd = d;
  endtask

  task automatic pulse();
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    req = 0;
    set_in(0,0,1,1,0,0,0,0,0,0,0,0,31,32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "reset verdict", {29'd0, acc, undf, trp}, 32'd0);
    chk("R3", "reset syn", {26'd0, syn}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      set_in(VT[v][0],VT[v][1],VT[v][2],VT[v][3],VT[v][4],VT[v][5],VT[v][6],
             VT[v][7],VT[v][8],VT[v][9],VT[v][10],VT[v][11],VT[v][12],32'h0);
      pulse();
      chk($sformatf("R%0d", VT[v][15]), $sformatf("vec %0d verdict", v),
          {29'd0, acc, undf, trp}, 32'(VT[v][13]));
      chk($sformatf("R%0d", VT[v][15]), $sformatf("vec %0d level", v), {30'd0, tel}, 32'(VT[v][14]));
      chk("R3", $sformatf("vec %0d syn", v), {26'd0, syn}, trp ? 32'h18 : 32'h0);
      @(negedge clk);
      chk("R2", $sformatf("vec %0d idle", v), {29'd0, acc, undf, trp}, 32'd0);
    end

    // R1 R10: masked write and readback
    set_in(3,1,1,1,0,0,0,0,0,0,0,5,31,32'hFFFF_FFFF); pulse();
    set_in(3,0,1,1,0,0,0,0,0,0,0,5,31,32'h0); pulse();
    chk("R10", "reserved bits", rd, 32'hFF00_FFFF);
    // R1 top index 30, and a neighbour untouched
    set_in(1,1,1,1,0,0,0,0,0,0,0,30,31,32'h8000_0001); pulse();
    chk("R1", "write verdict", {29'd0, acc, undf, trp}, 32'd4);
    set_in(0,0,1,1,0,0,0,0,0,0,0,30,31,32'h0); pulse();
    chk("R1", "readback 30", rd, 32'h8000_0001);
    set_in(0,0,1,1,0,0,0,0,0,0,0,29,31,32'h0); pulse();
    chk("R1", "readback 29", rd, 32'h0);
    // R9 ignored write beyond count, read as zero
    set_in(1,1,1,0,0,0,0,0,0,0,0,31,8,32'h1234_5678); pulse();
    chk("R9", "raz write verdict", {29'd0, acc, undf, trp}, 32'd4);
    set_in(3,0,1,0,0,0,0,0,0,0,0,31,31,32'h0); pulse();
    chk("R9", "raz read", rd, 32'h0);
    // R10 trapped write leaves entry
    set_in(3,1,1,1,0,0,0,0,0,0,0,10,31,32'h0000_AAAA); pulse();
    set_in(1,1,1,1,0,0,0,0,0,0,0,10,8,32'h0000_5555); pulse();
    chk("R8", "limit trap on write", {30'd0, tel}, 32'd2);
    set_in(1,1,1,1,0,0,0,0,0,1,0,10,31,32'h0000_5555); pulse();
    chk("R6", "tpm2 trap on write", {30'd0, tel}, 32'd2);
    set_in(3,0,1,1,0,0,0,0,0,0,0,10,31,32'h0); pulse();
    chk("R10", "entry kept", rd, 32'h0000_AAAA);
    // R9 limit-based count from level 1 without level 2 is full count
    set_in(1,0,1,0,0,0,0,0,0,0,0,10,4,32'h0); pulse();
    chk("R9", "no limit without level 2", rd, 32'h0000_AAAA);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule